// File: doc/BRIEF.md
# Trailing-Zero Vertex Packer

The block builds one compressed geometry record of 1024 bits from a stream of triangles. Each input beat carries one triangle as three vertices, and each vertex is three 32-bit floating-point coordinates. Vertices that exactly match one already held in the record are kept only once. The block tracks the smallest trailing-zero count over the bit patterns of all held coordinates. When the record is closed, every coordinate loses that many low bits, and the shortened values are laid end to end after a fixed 52-bit header.

A producer raises `in_start` on the first triangle of a record and `in_last` on its final one. A triangle that would break the vertex limit, the triangle limit or the 1024-bit budget is turned away, and `full` pulses so that the producer can send that triangle again in a fresh record. When the record is closed, the block shifts the coordinates into place one per clock. It then pulses `done` with the finished record on `rec`.

Top module: `tzv_packer`

## Requirements
- R1: After reset `in_ready` is 1, and `full` and `done` are 0.
- R2: A vertex whose 96 bits exactly equal a vertex already held in the current record, or an earlier vertex of the same triangle, is held only once. Header bits [4:0] give the number of distinct vertices held.
- R3: Header bits [10:5] give the shift s. This is the smallest trailing-zero count over every coordinate of every held vertex. An all-zero coordinate counts as 32, so a record with only zero coordinates, or with no vertices, has s = 32.
- R4: Header bits [15:11] give the number of accepted triangles. Header bits [51:16] are zero.
- R5: Each held coordinate is shifted right by s and takes 32 − s bits. The fields start at bit 52 and go upward, with x, y, z for each vertex and vertices in order of first appearance. On the vertex inputs, x is bits [31:0], y is bits [63:32] and z is bits [95:64].
- R6: Every record bit above 52 + 3·n·(32 − s) is zero, where n is the vertex count.
- R7: A triangle that would raise the distinct-vertex count above 16 is rejected. It leaves the record as if it had never been sent, and `full` is 1 on the cycle after that beat only.
- R8: A triangle is rejected in the same way if 52 + 3·n·(32 − s), computed with the n and s that would result, exceeds 1024.
- R9: A triangle that arrives when 16 triangles are already held is rejected in the same way.
- R10: A beat with `in_start` set discards everything held before, then applies its own triangle.
- R11: A beat with `in_last` set closes the record, whether or not its triangle is accepted. `in_ready` drops on the next cycle. `done` is 1 for exactly one cycle, 3·n + 1 cycles after the closing beat, and `rec` holds the record from then until the next record closes.
- R12: Input beats offered while `in_ready` is 0 have no effect on the record in progress or on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Triangle beat present |
| in_start | input | 1 | Beat opens a new record |
| in_last | input | 1 | Beat closes the record |
| in_v0 | input | 96 | First vertex {z, y, x} |
| in_v1 | input | 96 | Second vertex {z, y, x} |
| in_v2 | input | 96 | Third vertex {z, y, x} |
| in_ready | output | 1 | Block accepts beats |
| full | output | 1 | Previous beat's triangle was rejected |
| done | output | 1 | Record finished (one-cycle pulse) |
| rec | output | 1024 | Packed record |

## Verification
Some properties are checked on every cycle:
- `done` lasts exactly one cycle, and it only follows a cycle in which beats were refused.
- `in_ready` drops after a closing beat.
- `full` only follows an offered beat.
- Each finished record has header fields within their limits, and its bits past the used length are zero.

The bench scenarios cover the rest, which needs a model of the stream:
- the exact bit layout of the shortened fields;
- duplicate removal within and across triangles;
- the three rejection limits at their exact boundaries;
- the closing latency;
- restart on a new start beat;
- the fact that beats offered during packing have no effect.

// File: rtl/tzv_pkg.sv
`timescale 1ns/1ps
package tzv_pkg;
  localparam int NCOORD = 3;
  typedef enum logic {ST_FILL, ST_PACK} tzv_state_t;
endpackage

// File: rtl/tzv_ctz.sv
`timescale 1ns/1ps
module tzv_ctz #(
  parameter int CW = 32,
  parameter int ZW = $clog2(CW + 1)
) (
  input  logic [CW-1:0] word_i,
  output logic [ZW-1:0] zeros_o
);
  // lowest set bit index; an all-zero word reports CW
  always_comb begin
    zeros_o = ZW'(CW);
    for (int i = CW - 1; i >= 0; i--) begin
      if (word_i[i]) zeros_o = ZW'(i);
    end
  end
endmodule

// File: rtl/tzv_match.sv
`timescale 1ns/1ps
module tzv_match #(
  parameter int N  = 16,
  parameter int VW = 96
) (
  input  logic [N-1:0][VW-1:0] entries_i,
  input  logic [N-1:0]         live_i,
  input  logic [VW-1:0]        probe_i,
  output logic                 hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (live_i[k] && (entries_i[k] == probe_i)) hit_o = 1'b1;
    end
  end
endmodule

// File: rtl/tzv_packer.sv
`timescale 1ns/1ps
module tzv_packer
  import tzv_pkg::*;
#(
  parameter int MAX_VTX = 16,
  parameter int MAX_TRI = 16,
  parameter int REC_W   = 1024,
  parameter int HDR_W   = 52,
  parameter int CW      = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_start,
  input  logic                    in_last,
  input  logic [NCOORD*CW-1:0]    in_v0,
  input  logic [NCOORD*CW-1:0]    in_v1,
  input  logic [NCOORD*CW-1:0]    in_v2,
  output logic                    in_ready,
  output logic                    full,
  output logic                    done,
  output logic [REC_W-1:0]        rec
);
  localparam int VW     = NCOORD * CW;
  localparam int NIN    = NCOORD * NCOORD;
  localparam int CNT_W  = $clog2(MAX_VTX + 4);
  localparam int VI_W   = $clog2(MAX_VTX);
  localparam int HV_W   = $clog2(MAX_VTX + 1);
  localparam int TZ_W   = $clog2(CW + 1);
  localparam int TC_W   = $clog2(MAX_TRI + 1);
  localparam int PTR_W  = $clog2(REC_W + 1);
  localparam int SH_LSB = HV_W;
  localparam int TC_LSB = HV_W + TZ_W;

  logic [MAX_VTX-1:0][VW-1:0] vtx_q;
  logic [MAX_VTX-1:0]         live_q;
  logic [TC_W-1:0]            tri_q;
  logic [TZ_W-1:0]            tz_q;
  tzv_state_t                 st_q;
  logic [CNT_W-1:0]           vi_q;
  logic [1:0]                 ci_q;
  logic [PTR_W-1:0]           ptr_q;
  logic [REC_W-1:0]           rec_q;
  logic                       full_q, done_q;

  logic [NCOORD-1:0][VW-1:0]  vin;
  logic [NCOORD-1:0]          hit, fresh;
  logic [NCOORD-1:0][CNT_W-1:0] slot;
  logic [NIN-1:0][TZ_W-1:0]   ctz;
  logic [MAX_VTX-1:0]         base_live, new_live;
  logic [TC_W-1:0]            base_tri, fin_tri;
  logic [TZ_W-1:0]            base_tz, cand_tz, fin_tz;
  logic [CNT_W-1:0]           base_cnt, new_cnt, fin_cnt, vcnt;
  logic [15:0]                used;
  logic                       beat, reject, accept;
  logic [REC_W-1:0]           hdr;
  logic [VW-1:0]              cur_vtx;
  logic [CW-1:0]              piece;
  logic [PTR_W-1:0]           wid;

  assign vin[0] = in_v0;
  assign vin[1] = in_v1;
  assign vin[2] = in_v2;

  assign beat      = in_valid && (st_q == ST_FILL);
  assign base_live = in_start ? '0 : live_q;
  assign base_tri  = in_start ? '0 : tri_q;
  assign base_tz   = in_start ? TZ_W'(CW) : tz_q;
  assign base_cnt  = CNT_W'($countones(base_live));
  assign vcnt      = CNT_W'($countones(live_q));

  for (genvar j = 0; j < NCOORD; j++) begin : g_match
    tzv_match #(.N(MAX_VTX), .VW(VW)) u_match (
      .entries_i(vtx_q), .live_i(base_live), .probe_i(vin[j]), .hit_o(hit[j])
    );
  end

  for (genvar g = 0; g < NIN; g++) begin : g_ctz
    tzv_ctz #(.CW(CW), .ZW(TZ_W)) u_ctz (
      .word_i(vin[g / NCOORD][(g % NCOORD)*CW +: CW]), .zeros_o(ctz[g])
    );
  end

  always_comb begin
    fresh[0] = !hit[0];
    fresh[1] = !hit[1] && (vin[1] != vin[0]);
    fresh[2] = !hit[2] && (vin[2] != vin[0]) && (vin[2] != vin[1]);
    slot[0]  = base_cnt;
    slot[1]  = slot[0] + CNT_W'(fresh[0]);
    slot[2]  = slot[1] + CNT_W'(fresh[1]);
    new_cnt  = slot[2] + CNT_W'(fresh[2]);
    new_live = base_live;
    for (int k = 0; k < MAX_VTX; k++) begin
      for (int j = 0; j < NCOORD; j++) begin
        if (fresh[j] && (slot[j] == CNT_W'(k))) new_live[k] = 1'b1;
      end
    end
    cand_tz = base_tz;
    for (int g = 0; g < NIN; g++) begin
      if (ctz[g] < cand_tz) cand_tz = ctz[g];
    end
    used   = 16'(HDR_W) + 16'(NCOORD) * 16'(new_cnt) * (16'(CW) - 16'(cand_tz));
    reject = (base_tri >= TC_W'(MAX_TRI)) || (new_cnt > CNT_W'(MAX_VTX)) ||
             (used > 16'(REC_W));
    accept  = beat && !reject;
    fin_cnt = accept ? new_cnt : base_cnt;
    fin_tz  = accept ? cand_tz : base_tz;
    fin_tri = accept ? base_tri + TC_W'(1) : base_tri;
    hdr = '0;
    hdr[HV_W-1:0]         = fin_cnt[HV_W-1:0];
    hdr[SH_LSB +: TZ_W]   = fin_tz;
    hdr[TC_LSB +: TC_W]   = fin_tri;
  end

  assign cur_vtx = vtx_q[vi_q[VI_W-1:0]];
  assign piece   = cur_vtx[ci_q*CW +: CW] >> tz_q;
  assign wid     = PTR_W'(CW) - PTR_W'(tz_q);

  // vertex table: written on accept only, no reset needed
  always_ff @(posedge clk) begin
    for (int k = 0; k < MAX_VTX; k++) begin
      for (int j = 0; j < NCOORD; j++) begin
        if (accept && fresh[j] && (slot[j] == CNT_W'(k))) vtx_q[k] <= vin[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_FILL;
      live_q <= '0;
      tri_q  <= '0;
      tz_q   <= TZ_W'(CW);
      full_q <= 1'b0;
      done_q <= 1'b0;
      vi_q   <= '0;
      ci_q   <= '0;
      ptr_q  <= '0;
      rec_q  <= '0;
    end else begin
      full_q <= beat && reject;
      done_q <= 1'b0;
      case (st_q)
        ST_FILL: begin
          if (beat) begin
            live_q <= accept ? new_live : base_live;
            tri_q  <= fin_tri;
            tz_q   <= fin_tz;
            if (in_last) begin
              st_q  <= ST_PACK;
              rec_q <= hdr;
              vi_q  <= '0;
              ci_q  <= '0;
              ptr_q <= PTR_W'(HDR_W);
            end
          end
        end
        default: begin
          if (vi_q == vcnt) begin
            done_q <= 1'b1;
            st_q   <= ST_FILL;
          end else begin
            rec_q <= rec_q | (REC_W'(piece) << ptr_q);
            ptr_q <= ptr_q + wid;
            if (ci_q == 2'(NCOORD - 1)) begin
              ci_q <= '0;
              vi_q <= vi_q + CNT_W'(1);
            end else begin
              ci_q <= ci_q + 2'd1;
            end
          end
        end
      endcase
    end
  end

  assign in_ready = (st_q == ST_FILL);
  assign full     = full_q;
  assign done     = done_q;
  assign rec      = rec_q;
endmodule

// File: rtl/tzv_packer_chk.sv
`timescale 1ns/1ps
module tzv_packer_chk #(
  parameter int MAX_VTX = 16,
  parameter int MAX_TRI = 16,
  parameter int REC_W   = 1024,
  parameter int HDR_W   = 52,
  parameter int CW      = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_last,
  input logic             in_ready,
  input logic             full,
  input logic             done,
  input logic [REC_W-1:0] rec
);
  localparam int HV_W = $clog2(MAX_VTX + 1);
  localparam int TZ_W = $clog2(CW + 1);
  localparam int TC_W = $clog2(MAX_TRI + 1);

  logic [HV_W-1:0] vf;
  logic [TZ_W-1:0] sf;
  logic [TC_W-1:0] tf;
  logic [15:0]     used_w;

  assign vf = rec[HV_W-1:0];
  assign sf = rec[HV_W +: TZ_W];
  assign tf = rec[HV_W + TZ_W +: TC_W];
  assign used_w = 16'(HDR_W) + 16'(3) * 16'(vf) * (16'(CW) - 16'(sf));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  close_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R12
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(in_ready));

  // R7
  full_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> $past(in_valid && in_ready));

  // R2
  header_limits_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ((vf <= HV_W'(MAX_VTX)) && (tf <= TC_W'(MAX_TRI)) && (sf <= TZ_W'(CW))));

  // R6
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ((rec >> used_w) == '0));
endmodule

bind tzv_packer tzv_packer_chk #(
  .MAX_VTX(MAX_VTX), .MAX_TRI(MAX_TRI), .REC_W(REC_W), .HDR_W(HDR_W), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
  .in_ready(in_ready), .full(full), .done(done), .rec(rec)
);

// File: tb/tzv_packer_tb.sv
`timescale 1ns/1ps
module tzv_packer_tb;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_start, in_last;
  logic [95:0] in_v0, in_v1, in_v2;
  logic in_ready, full, done;
  logic [1023:0] rec;

  int n_chk = 0;
  int n_bad = 0;

  logic [95:0] mv [0:15];
  int mn, mtri, mtz;

  always #2.5 clk = ~clk;

  tzv_packer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_last(in_last),
    .in_v0(in_v0), .in_v1(in_v1), .in_v2(in_v2),
    .in_ready(in_ready), .full(full), .done(done), .rec(rec)
  );

  task automatic chk_val(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_rec(string tag, logic [1023:0] act, logic [1023:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s record: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bctz(logic [31:0] w);
    for (int i = 0; i < 32; i++) if (w[i]) return i;
    return 32;
  endfunction

  function automatic logic [95:0] vx(logic [31:0] x, logic [31:0] y, logic [31:0] z);
    return {z, y, x};
  endfunction

  // bench model of the requirements
  task automatic model_add(logic [95:0] a, logic [95:0] b, logic [95:0] c,
                           bit s, output bit rej);
    logic [95:0] t [0:2];
    logic [95:0] nf [0:2];
    int cnt, ntz, nn, used;
    t[0] = a; t[1] = b; t[2] = c;
    if (s) begin mn = 0; mtri = 0; mtz = 32; end
    cnt = 0;
    ntz = mtz;
    for (int j = 0; j < 3; j++) begin
      bit dup = 0;
      for (int k = 0; k < mn; k++) if (mv[k] == t[j]) dup = 1;
      for (int i = 0; i < j; i++) if (t[i] == t[j]) dup = 1;
      if (!dup) begin nf[cnt] = t[j]; cnt++; end
      for (int q = 0; q < 3; q++) if (bctz(t[j][q*32 +: 32]) < ntz) ntz = bctz(t[j][q*32 +: 32]);
    end
    nn = mn + cnt;
    used = 52 + 3 * nn * (32 - ntz);
    rej = (mtri >= 16) || (nn > 16) || (used > 1024);
    if (!rej) begin
      for (int j = 0; j < cnt; j++) mv[mn + j] = nf[j];
      mn = nn; mtri++; mtz = ntz;
    end
  endtask

  function automatic logic [1023:0] exp_rec();
    logic [1023:0] r = '0;
    int p = 52;
    r[4:0] = 5'(mn);
    r[10:5] = 6'(mtz);
    r[15:11] = 5'(mtri);
    for (int i = 0; i < mn; i++)
      for (int q = 0; q < 3; q++) begin
        logic [31:0] pc = (mtz >= 32) ? 32'd0 : (mv[i][q*32 +: 32] >> mtz);
        r = r | (1024'(pc) << p);
        p += 32 - mtz;
      end
    return r;
  endfunction

  task automatic send(logic [95:0] a, logic [95:0] b, logic [95:0] c,
                      bit s, bit l, string tag);
    bit rej;
    model_add(a, b, c, s, rej);
    @(negedge clk);
    in_valid = 1; in_start = s; in_last = l; in_v0 = a; in_v1 = b; in_v2 = c;
    @(negedge clk);
    in_valid = 0; in_start = 0; in_last = 0;
    chk_val(tag, "full flag", full, rej);
  endtask

  task automatic close_check(string tag, bit junk);
    int cyc = 0;
    while (!done && cyc < 400) begin
      if (junk) begin
        in_valid = 1; in_start = 1; in_last = 1;
        in_v0 = {96{1'b1}}; in_v1 = 96'h5; in_v2 = 96'h7;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 0; in_start = 0; in_last = 0;
    chk_val(tag, "done seen", done, 1);
    chk_val("R11", "close latency", cyc, 3 * mn + 1);
    chk_rec(tag, rec, exp_rec());
    @(negedge clk);
    chk_val("R11", "done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk_val("R1", "ready", in_ready, 1);
    chk_val("R1", "full", full, 0);
    chk_val("R1", "done", done, 0);
  endtask

  task automatic t_basic();
    logic [95:0] a = vx(32'h3F800000, 32'h40000000, 32'h40400000);
    logic [95:0] b = vx(32'h3F800000, 32'h3F800000, 32'h3F800000);
    logic [95:0] c = vx(32'h3F800000, 32'h40400000, 32'h40000000);
    send(a, b, c, 1, 1, "R5");
    close_check("R5", 0);
    chk_val("R3", "shift field", rec[10:5], 22);
    chk_val("R4", "tri field", rec[15:11], 1);
    chk_val("R4", "reserved header", rec[51:16], 0);
    chk_val("R5", "first field x of v0", rec[61:52], 32'h3F800000 >> 22);
  endtask

  task automatic t_dedup();
    logic [95:0] a = vx(32'h100, 32'h200, 32'h300);
    logic [95:0] b = vx(32'h400, 32'h500, 32'h600);
    logic [95:0] c = vx(32'h700, 32'h800, 32'h900);
    logic [95:0] d = vx(32'hA00, 32'hB00, 32'hC00);
    send(a, b, c, 1, 0, "R2");
    send(b, c, d, 0, 0, "R2");
    send(a, a, d, 0, 1, "R2");
    close_check("R2", 0);
    chk_val("R2", "vertex count", rec[4:0], 4);
    chk_val("R4", "tri count", rec[15:11], 3);
  endtask

  task automatic t_zero();
    logic [95:0] a = vx(32'h0, 32'h3F800000, 32'h40000000);
    logic [95:0] b = vx(32'h0, 32'h0, 32'h0);
    logic [95:0] c = vx(32'h3F800000, 32'h0, 32'h40000000);
    send(a, b, c, 1, 1, "R3");
    close_check("R3", 0);
    chk_val("R3", "zeros ignored in shift", rec[10:5], 23);
  endtask

  task automatic t_allzero();
    send(96'h0, 96'h0, 96'h0, 1, 1, "R3");
    close_check("R6", 0);
    chk_val("R3", "all-zero shift", rec[10:5], 32);
    chk_val("R6", "data bits", rec[1023:16] == '0, 1);
  endtask

  task automatic t_vlimit();
    logic [95:0] v [0:16];
    for (int i = 0; i < 17; i++) v[i] = vx(32'(i + 1) << 16, 32'h40000000, 32'h0);
    send(v[0], v[1], v[2], 1, 0, "R7");
    for (int t = 1; t < 5; t++) send(v[3*t], v[3*t+1], v[3*t+2], 0, 0, "R7");
    send(v[15], v[0], v[1], 0, 0, "R7");
    send(v[16], v[0], v[1], 0, 0, "R7");
    send(v[0], v[1], v[2], 0, 1, "R7");
    close_check("R7", 0);
    chk_val("R7", "vertex count at limit", rec[4:0], 16);
    chk_val("R7", "tri count", rec[15:11], 7);
  endtask

  task automatic t_budget();
    logic [95:0] v [0:12];
    for (int i = 0; i < 13; i++) v[i] = vx(32'(2*i + 1), 32'(4*i + 3), 32'h1);
    send(v[0], v[1], v[2], 1, 0, "R8");
    send(v[3], v[4], v[5], 0, 0, "R8");
    send(v[6], v[7], v[8], 0, 0, "R8");
    send(v[9], v[10], v[11], 0, 0, "R8");
    send(v[9], v[0], v[1], 0, 1, "R8");
    close_check("R8", 0);
    chk_val("R8", "vertex count at budget", rec[4:0], 10);
  endtask

  task automatic t_tlimit();
    logic [95:0] a = vx(32'h10, 32'h20, 32'h30);
    logic [95:0] b = vx(32'h40, 32'h50, 32'h60);
    logic [95:0] c = vx(32'h70, 32'h80, 32'h90);
    send(a, b, c, 1, 0, "R9");
    for (int t = 1; t < 16; t++) send(a, b, c, 0, 0, "R9");
    send(a, b, c, 0, 1, "R9");
    close_check("R9", 0);
    chk_val("R9", "tri count at limit", rec[15:11], 16);
  endtask

  task automatic t_restart();
    logic [95:0] a = vx(32'hF000, 32'hF100, 32'hF200);
    send(a, a, a, 1, 0, "R10");
    send(vx(32'h8, 32'h8, 32'h8), vx(32'h18, 32'h8, 32'h8), vx(32'h28, 32'h8, 32'h8), 1, 1, "R10");
    close_check("R10", 0);
    chk_val("R10", "vertex count after restart", rec[4:0], 3);
    chk_val("R10", "shift after restart", rec[10:5], 3);
  endtask

  task automatic t_ignore();
    logic [95:0] a = vx(32'h3000, 32'h5000, 32'h7000);
    logic [95:0] b = vx(32'h9000, 32'hB000, 32'hD000);
    send(a, b, a, 1, 1, "R12");
    close_check("R12", 1);
    send(b, b, b, 1, 1, "R12");
    close_check("R12", 0);
    chk_val("R12", "next record count", rec[4:0], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; in_valid = 0; in_start = 0; in_last = 0;
    in_v0 = '0; in_v1 = '0; in_v2 = '0;
    mn = 0; mtri = 0; mtz = 32;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dedup();
    t_zero();
    t_allzero();
    t_vlimit();
    t_budget();
    t_tlimit();
    t_restart();
    t_ignore();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule